// File: doc/BRIEF.md
# I2C Target with Byte Register Bank

This block is an I2C target. It lets a bus master read and write a small bank of byte-wide registers. The bank can hold up to 128 locations. SCL and SDA come in from open-drain pads and pass through two-flop synchronizers. The block pulls SDA low through an output enable and never drives SCL. The SCL enable is tied inactive.

A write transaction has three parts: the device address with the write bit, a sub-address byte, and any number of data bytes. In the sub-address byte, the top bit turns on pointer auto-increment and the low seven bits select the register. A read transaction starts the same way to set the pointer. The master then issues a repeated START and sends the address with the read bit. The target returns bytes from the pointer until the master answers with a NACK.

Each stored byte is also reported on a one-cycle write strobe that carries its address and data. A side read port lets local logic look at any register at any time. A synchronous reset returns the block to idle and releases SDA.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sdaOe is 0, wrStrobe is 0, and every register reads 0x00 on the side port.
- R2: The first byte after START is sent MSB first as a 7-bit address followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged. A mismatch gets no acknowledge, and all bytes until the next START or STOP are ignored: no strobe and no register change.
- R3: After each byte the block receives and accepts, it holds SDA low for the whole high phase of the ninth SCL pulse.
- R4: In a write, the byte after the address is the sub-address. Bits [6:0] set the pointer and bit 7 = 1 enables auto-increment. Each following data byte is stored at the pointer and reported once on wrStrobe with wrAddr and wrData. The pointer then advances by one.
- R5: With bit 7 of the sub-address at 0, the pointer stays fixed for every data byte of a write or read burst.
- R6: After a repeated START and the address with the read bit, the block drives register bytes MSB first, starting at the pointer. The pointer advances after each byte when auto-increment is on.
- R7: A master ACK (SDA low on the ninth clock) during a read brings another byte. A master NACK releases SDA, and the block does not drive SDA again until a START.
- R8: With auto-increment on, the pointer wraps from 0x7F to 0x00.
- R9: Locations at or above NUM_REGS (default 16) read as 0x00. Writes to them still strobe but leave the bank unchanged.
- R10: A START in the middle of a byte abandons it. The block restarts address reception from bit 7.
- R11: sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | SCL pad input |
| sdaIn | input | 1 | SDA pad input |
| sdaOe | output | 1 | 1 pulls SDA low |
| sclOe | output | 1 | SCL pull-down enable, tied to 0 |
| wrStrobe | output | 1 | One-cycle pulse per data byte written |
| wrAddr | output | 7 | Register address of the written byte |
| wrData | output | 8 | Value of the written byte |
| userAddr | input | 7 | Side port register select |
| userRdData | output | 8 | Side port register value |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes a START or STOP. Each SCL phase lasts many clocks longer than the synchronizer delay, so the target's SDA changes always land inside the low phase. The bench master holds every quarter bit for 20 clocks. It releases SDA whenever the target may drive, and it resolves the open-drain line as the AND of both drivers.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RX, S_ACK1, S_ACK2, S_TX, S_TXREL, S_TXACK, S_TXNEXT, S_IGNORE
  } ctrlState_t;

  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA, K_TX} byteKind_t;

  typedef struct packed {
    logic shiftIn;
    logic takeSub;
    logic writeData;
    logic loadTx;
    logic shiftTx;
  } dpStb_t;

endpackage

// File: rtl/i2c_tgt_data.sv
module i2c_tgt_data
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStb_t            stb,
  input  logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              txLoadBit,
  output logic              txNextBit,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] userAddr,
  output logic [DATA_W-1:0] userRdData
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

  logic [DATA_W-1:0] rxShift, txShift, rdData;
  logic [ADDR_W-1:0] ptr;
  logic              autoInc;
  logic [DATA_W-1:0] bank [NUM_REGS];

  assign rxByte    = {rxShift[DATA_W-2:0], sdaBit};
  assign rdData    = ({1'b0, ptr} < LIMIT) ? bank[ptr[IDX_W-1:0]] : '0;
  assign txLoadBit = rdData[DATA_W-1];
  assign txNextBit = txShift[DATA_W-2];
  assign userRdData = ({1'b0, userAddr} < LIMIT) ? bank[userAddr[IDX_W-1:0]] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) bank[g] <= '0;
      else if (stb.writeData && ptr == ADDR_W'(g)) bank[g] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift  <= '0;
      txShift  <= '0;
      ptr      <= '0;
      autoInc  <= 1'b0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= stb.writeData;
      if (stb.shiftIn) rxShift <= rxByte;
      if (stb.takeSub) begin
        ptr     <= rxByte[ADDR_W-1:0];
        autoInc <= rxByte[DATA_W-1];
      end
      if (stb.writeData) begin
        wrAddr <= ptr;
        wrData <= rxByte;
        ptr    <= ptr + ADDR_W'(autoInc);
      end
      if (stb.loadTx) begin
        txShift <= rdData;
        ptr     <= ptr + ADDR_W'(autoInc);
      end else if (stb.shiftTx) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R8: the pointer rolls over from the top address to zero
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ((stb.writeData || stb.loadTx) && autoInc && ptr == '1) |=> (ptr == '0));

  // R5: a fixed pointer stays put across data bytes
  p_ptr_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    ((stb.writeData || stb.loadTx) && !autoInc && !stb.takeSub) |=> $stable(ptr));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int           ADDR_W      = 7,
  parameter int           DATA_W      = 8,
  parameter logic [6:0]   TARGET_ADDR = 7'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txLoadBit,
  input  logic              txNextBit,
  output dpStb_t            stb,
  output logic              sdaBit,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ, sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;

  ctrlState_t      state, stateD;
  byteKind_t       kind, kindD, nextKind, nextKindD;
  logic [CNT_W-1:0] bitCnt, bitCntD;
  logic            oeD;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sdaBit   = sdaS;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;

  always_comb begin
    stateD    = state;
    kindD     = kind;
    nextKindD = nextKind;
    bitCntD   = bitCnt;
    oeD       = sdaOe;
    stb       = '0;
    if (startDet) begin
      stateD  = S_RX;
      kindD   = K_ADDR;
      bitCntD = '0;
      oeD     = 1'b0;
    end else if (stopDet) begin
      stateD = S_IDLE;
      oeD    = 1'b0;
    end else begin
      case (state)
        S_RX: if (sclRise) begin
          stb.shiftIn = 1'b1;
          bitCntD     = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) begin
            case (kind)
              K_ADDR: begin
                if (rxByte[DATA_W-1:1] == TARGET_ADDR) begin
                  stateD    = S_ACK1;
                  nextKindD = rxByte[0] ? K_TX : K_SUB;
                end else begin
                  stateD = S_IGNORE;
                end
              end
              K_SUB: begin
                stb.takeSub = 1'b1;
                stateD      = S_ACK1;
                nextKindD   = K_DATA;
              end
              default: begin
                stb.writeData = 1'b1;
                stateD        = S_ACK1;
                nextKindD     = K_DATA;
              end
            endcase
          end
        end
        S_ACK1: if (sclFall) begin
          oeD    = 1'b1;
          stateD = S_ACK2;
        end
        S_ACK2: if (sclFall) begin
          bitCntD = '0;
          if (nextKind == K_TX) begin
            stb.loadTx = 1'b1;
            oeD        = ~txLoadBit;
            stateD     = S_TX;
          end else begin
            oeD    = 1'b0;
            kindD  = nextKind;
            stateD = S_RX;
          end
        end
        S_TX: begin
          if (sclRise) begin
            bitCntD = bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) stateD = S_TXREL;
          end else if (sclFall) begin
            stb.shiftTx = 1'b1;
            oeD         = ~txNextBit;
          end
        end
        S_TXREL: if (sclFall) begin
          oeD    = 1'b0;
          stateD = S_TXACK;
        end
        S_TXACK: if (sclRise) stateD = sdaS ? S_IGNORE : S_TXNEXT;
        S_TXNEXT: if (sclFall) begin
          stb.loadTx = 1'b1;
          oeD        = ~txLoadBit;
          bitCntD    = '0;
          stateD     = S_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      nextKind <= K_SUB;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      state    <= stateD;
      kind     <= kindD;
      nextKind <= nextKindD;
      bitCnt   <= bitCntD;
      sdaOe    <= oeD;
    end
  end

  // R11: the SDA drive moves only in the low phase of SCL
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sdaOe != $past(sdaOe)) |-> !sclS);

  // R3: the acknowledge stays low through the ninth high phase
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK2 && sclS) |-> sdaOe);

  // R7: a master NACK leaves SDA released
  p_nack_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_TXACK && sclRise && sdaS && !startDet && !stopDet) |=> !sdaOe);

  // R2: an unaddressed target neither drives nor writes
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IGNORE) |-> (!sdaOe && !stb.writeData && !stb.loadTx));

  // R10: a START always restarts address reception
  p_start_restart_r10: assert property (@(posedge clk) disable iff (rst)
    startDet |=> (state == S_RX && kind == K_ADDR && bitCnt == '0));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] TARGET_ADDR = 7'h1D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic       sclOe,
  output logic       wrStrobe,
  output logic [6:0] wrAddr,
  output logic [7:0] wrData,
  input  logic [6:0] userAddr,
  output logic [7:0] userRdData
);
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  dpStb_t            stb;
  logic              sdaBit, txLoadBit, txNextBit;
  logic [DATA_W-1:0] rxByte;

  assign sclOe = 1'b0;

  i2c_tgt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET_ADDR(TARGET_ADDR)
  ) i_ctrl (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txLoadBit(txLoadBit), .txNextBit(txNextBit),
    .stb(stb), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  i2c_tgt_data #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_data (
    .clk(clk), .rst(rst), .stb(stb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txLoadBit(txLoadBit), .txNextBit(txNextBit),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .userAddr(userAddr), .userRdData(userRdData)
  );

endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int Q = 20;
  localparam logic [7:0] AW = {7'h1D, 1'b0};
  localparam logic [7:0] AR = {7'h1D, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sclOe, wrStrobe;
  logic [6:0] wrAddr, userAddr = '0;
  logic [7:0] wrData, userRdData;
  logic sdaLine;

  int nTests = 0, nFail = 0, oeViol = 0;
  bit finished = 0;
  logic [14:0] expQ [$];
  logic prevOe = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst(rst), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .sclOe(sclOe), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .userAddr(userAddr), .userRdData(userRdData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (!rst && wrStrobe) begin
      if (expQ.size() == 0) begin
        check(0, "R2/R4 unexpected write strobe", {wrAddr, wrData}, 0);
      end else begin
        logic [14:0] e;
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R4 write strobe addr/data", {wrAddr, wrData}, e);
      end
    end
  end

  // R11 monitor: the target changes SDA only while SCL is low
  always @(negedge clk) begin
    if (!rst && sdaOe != prevOe && sclM) oeViol++;
    prevOe <= sdaOe;
  end

  task automatic busStart();
    waitq(Q); sdaM = 1'b1; waitq(Q); sclM = 1'b1;
    waitq(2*Q); sdaM = 1'b0; waitq(2*Q); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitq(Q); sdaM = 1'b0; waitq(Q); sclM = 1'b1;
    waitq(2*Q); sdaM = 1'b1; waitq(2*Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      waitq(Q); sdaM = b[i]; waitq(Q); sclM = 1'b1; waitq(2*Q); sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic a1, a2;
    sendBits(b, 8);
    waitq(Q); sdaM = 1'b1; waitq(Q); sclM = 1'b1;
    waitq(1); a1 = sdaLine; waitq(2*Q - 2); a2 = sdaLine;
    waitq(1); sclM = 1'b0;
    acked = !a1 && !a2;
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitq(Q); sdaM = 1'b1; waitq(Q); sclM = 1'b1;
      waitq(Q); b[i] = sdaLine; waitq(Q); sclM = 1'b0;
    end
    waitq(Q); sdaM = masterAck ? 1'b0 : 1'b1; waitq(Q); sclM = 1'b1;
    waitq(2*Q); sclM = 1'b0;
  endtask

  task automatic sendAcked(input logic [7:0] b, input string tag);
    bit ak;
    sendByte(b, ak);
    check(ak, tag, ak, 1);
  endtask

  task automatic pushExp(input logic [6:0] a, input logic [7:0] d);
    expQ.push_back({a, d});
  endtask

  task automatic peek(input logic [6:0] a, input logic [7:0] exp, input string tag);
    userAddr = a; waitq(2);
    check(userRdData == exp, tag, userRdData, exp);
  endtask

  task automatic setPtrRead(input logic [7:0] sub);
    busStart();
    sendAcked(AW, "R2 address ack");
    sendAcked(sub, "R3 sub-address ack");
    busStart();
    sendAcked(AR, "R6 read address ack");
  endtask

  initial begin
    logic [7:0] rb;
    bit ak;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    waitq(4);
    // R1: reset state
    check(sdaOe == 1'b0, "R1 sdaOe after reset", sdaOe, 0);
    check(wrStrobe == 1'b0, "R1 wrStrobe after reset", wrStrobe, 0);
    peek(7'h02, 8'h00, "R1 register zero after reset");

    // R4, R3: auto-increment write burst from 0x02
    busStart();
    sendAcked(AW, "R2 address ack");
    sendAcked(8'h82, "R3 sub-address ack");
    pushExp(7'h02, 8'hA1); sendAcked(8'hA1, "R3 data ack");
    pushExp(7'h03, 8'hB2); sendAcked(8'hB2, "R3 data ack");
    pushExp(7'h04, 8'hC3); sendAcked(8'hC3, "R3 data ack");
    busStop();
    peek(7'h02, 8'hA1, "R4 burst reg 2");
    peek(7'h03, 8'hB2, "R4 burst reg 3");
    peek(7'h04, 8'hC3, "R4 burst reg 4");

    // R5: fixed pointer write
    busStart();
    sendAcked(AW, "R2 address ack");
    sendAcked(8'h05, "R3 sub-address ack");
    pushExp(7'h05, 8'h11); sendAcked(8'h11, "R5 data ack");
    pushExp(7'h05, 8'h22); sendAcked(8'h22, "R5 data ack");
    pushExp(7'h05, 8'h33); sendAcked(8'h33, "R5 data ack");
    busStop();
    peek(7'h05, 8'h33, "R5 last byte at fixed address");
    peek(7'h06, 8'h00, "R5 neighbour untouched");

    // R6, R7: auto-increment read with final NACK
    setPtrRead(8'h82);
    recvByte(1'b1, rb); check(rb == 8'hA1, "R6 read byte 0", rb, 8'hA1);
    recvByte(1'b1, rb); check(rb == 8'hB2, "R6 read byte 1", rb, 8'hB2);
    recvByte(1'b0, rb); check(rb == 8'hC3, "R6 read byte 2", rb, 8'hC3);
    waitq(Q);
    check(sdaOe == 1'b0, "R7 SDA released after NACK", sdaOe, 0);
    recvByte(1'b1, rb); check(rb == 8'hFF, "R7 no drive after NACK", rb, 8'hFF);
    busStop();

    // R5: fixed pointer read
    setPtrRead(8'h05);
    recvByte(1'b1, rb); check(rb == 8'h33, "R5 fixed read 0", rb, 8'h33);
    recvByte(1'b0, rb); check(rb == 8'h33, "R5 fixed read 1", rb, 8'h33);
    busStop();

    // R8, R9: wrap across the top, unimplemented location discarded
    busStart();
    sendAcked(AW, "R2 address ack");
    sendAcked(8'hFF, "R3 sub-address ack");
    pushExp(7'h7F, 8'h5A); sendAcked(8'h5A, "R9 data ack unimplemented");
    pushExp(7'h00, 8'h6B); sendAcked(8'h6B, "R8 data ack after wrap");
    busStop();
    peek(7'h00, 8'h6B, "R8 wrapped write at 0x00");
    peek(7'h7F, 8'h00, "R9 unimplemented side read");
    setPtrRead(8'hFE);
    recvByte(1'b1, rb); check(rb == 8'h00, "R9 read 0x7E", rb, 0);
    recvByte(1'b1, rb); check(rb == 8'h00, "R9 read 0x7F", rb, 0);
    recvByte(1'b0, rb); check(rb == 8'h6B, "R8 read wraps to 0x00", rb, 8'h6B);
    busStop();

    // R2: address mismatch is not acknowledged and traffic is ignored
    busStart();
    sendByte({7'h2A, 1'b0}, ak);
    check(!ak, "R2 mismatch not acknowledged", ak, 0);
    sendByte(8'h83, ak);
    check(!ak, "R2 ignored byte not acknowledged", ak, 0);
    sendByte(8'h99, ak);
    busStop();
    peek(7'h03, 8'hB2, "R2 register unchanged after mismatch");

    // R10: START inside a byte aborts it
    busStart();
    sendAcked(AW, "R2 address ack");
    sendBits(8'hFF, 4);
    busStart();
    sendAcked(AW, "R10 address ack after abort");
    sendAcked(8'h06, "R10 sub-address ack");
    pushExp(7'h06, 8'h77); sendAcked(8'h77, "R10 data ack");
    busStop();
    peek(7'h06, 8'h77, "R10 write after aborted byte");

    waitq(10);
    check(oeViol == 0, "R11 SDA changes while SCL high", oeViol, 0);
    check(expQ.size() == 0, "R4 all expected writes seen", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule